// File: doc/BRIEF.md
# Flash Protection Control Registers

This block holds the three byte-wide control registers that guard a flash array's configuration and its boot area. Software reaches them over a simple synchronous register bus. Writes are sampled on the clock edge. Read data is a combinational function of the address.

A lock state machine controls how often the lock bit may be written:

| State | Lock bit | Meaning |
|-------|----------|---------|
| `LK_FRESH` | 0 | The one normal-mode write is still available. |
| `LK_SPENT` | 0 | The normal-mode write has been used with a 0. |
| `LK_SET` | 1 | The lock is set. |

Transitions:

- **Normal mode**, write to the lock register:
  - `LK_FRESH` goes to `LK_SET` when bit 0 is 1.
  - `LK_FRESH` goes to `LK_SPENT` when bit 0 is 0.
  - `LK_SPENT` and `LK_SET` do not react.
- **Special mode**, write to the lock register, from any state:
  - Goes to `LK_SET` when bit 0 is 1.
  - Goes to `LK_FRESH` when bit 0 is 0.
- **Reset** returns to `LK_FRESH`.

A set lock freezes the configuration register. That register holds the boot-protect bit. While boot-protect is set, erase or program requests that fall inside the boot window are refused. The window covers the top 2 KB or the top 1 KB of whichever half of the 64 KB space holds the array.

The request checker is purely combinational. A request presented for one cycle gets an allow or deny answer in that same cycle.

Top module: `flash_guard_regs`

## Requirements
- R1: After reset, the lock register at address 0xF4 reads 0x00, the configuration register at 0xF5 reads 0x01 (boot-protect = bit 0 = 1), and the test register at 0xF6 reads 0x00.
- R2: In normal mode (`mode_special`=0), the first write to 0xF4 after reset loads bit 0 of the write data into the lock bit. Every later normal-mode write to 0xF4 leaves the lock bit unchanged until the next reset.
- R3: In special mode, every write to 0xF4 loads bit 0 of the write data into the lock bit. Writing 0 in special mode makes the single normal-mode write available again.
- R4: While the lock bit is 1, writes to 0xF5 leave the configuration register unchanged.
- R5: While `pgm_enable` is 1, writes to 0xF5 leave the configuration register unchanged.
- R6: When the lock bit is 0 and `pgm_enable` is 0, a write to 0xF5 loads bit 0 of the write data into boot-protect. The new value is visible in the next cycle.
- R7: In normal mode, writes to 0xF6 have no effect, and 0xF6 reads 0x00.
- R8: In special mode, 0xF6 is a readable and writable 8-bit register. Any cycle spent in normal mode clears it to 0x00.
- R9: Bits 7..1 of 0xF4 and 0xF5 read 0 and ignore writes. Every address other than 0xF4–0xF6 reads 0x00.
- R10: The boot window is the top 2 KB of the selected half of the address space: 0x7800–0x7FFF when `map_high`=0, and 0xF800–0xFFFF when `map_high`=1. With `boot_small`=1 the window shrinks to the top 1 KB: 0x7C00–0x7FFF or 0xFC00–0xFFFF.
- R11: In the cycle that `req_valid` is 1, `req_deny` is 1 exactly when boot-protect is 1 and `req_addr` lies in the boot window. `req_allow` is 1 exactly in the other valid cases.
- R12: While `req_valid` is 0, both `req_allow` and `req_deny` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_special | input | 1 | 1 = special mode, 0 = normal mode |
| reg_addr | input | 8 | Register bus address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data (combinational from `reg_addr`) |
| pgm_enable | input | 1 | Program/erase sequence active; freezes boot-protect |
| map_high | input | 1 | Array mapped in the upper half of the address space |
| boot_small | input | 1 | 1 KB boot window instead of 2 KB |
| req_valid | input | 1 | Erase/program request present |
| req_addr | input | 16 | Target address of the request |
| req_allow | output | 1 | Request permitted (same cycle) |
| req_deny | output | 1 | Request refused (same cycle) |

## Verification
The hardest behaviour to reach is the special-mode lock rewrite, which has to be followed by a normal-mode write. This checks that a special-mode 0 returns the machine to `LK_FRESH` rather than `LK_SPENT`. The stimulus sets and clears the lock several times in special mode, drops to normal mode, spends the single write, and then confirms that a second write is ignored. It also probes every window edge (one below, first, and last address) for both mappings and both block sizes, with boot-protect set and then cleared.

// File: rtl/fg_pkg.sv
package fg_pkg;
    typedef enum logic [1:0] {
        LK_FRESH = 2'd0,
        LK_SPENT = 2'd1,
        LK_SET   = 2'd2
    } lock_state_e;

    localparam int REG_LOCK_OFS = 0;
    localparam int REG_CFG_OFS  = 1;
    localparam int REG_TST_OFS  = 2;
endpackage

// File: rtl/fg_lock_fsm.sv
module fg_lock_fsm
    import fg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic special,
    input  logic wr_lock,
    input  logic wbit,
    output logic lock_o
);
    lock_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LK_FRESH;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (wr_lock) begin
            if (special) begin
                state_d = wbit ? LK_SET : LK_FRESH;
            end else begin
                unique case (state_q)
                    LK_FRESH: state_d = wbit ? LK_SET : LK_SPENT;
                    LK_SPENT: state_d = LK_SPENT;
                    LK_SET:   state_d = LK_SET;
                    default:  state_d = LK_SET;
                endcase
            end
        end
    end

    always_comb begin
        lock_o = (state_q == LK_SET);
    end

    p_lock_once_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lock && !special && state_q != LK_FRESH) |=> $stable(lock_o));

    p_special_rewrite_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lock && special) |=> (lock_o == $past(wbit)));
endmodule

// File: rtl/fg_cfg_reg.sv
module fg_cfg_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_cfg,
    input  logic lock_i,
    input  logic pgm_enable,
    input  logic wbit,
    output logic bootp_o
);
    logic upd;

    always_comb upd = wr_cfg && !lock_i && !pgm_enable;

    always_ff @(posedge clk) begin
        if (!rst_n)   bootp_o <= 1'b1;
        else if (upd) bootp_o <= wbit;
    end

    p_cfg_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cfg && lock_i) |=> $stable(bootp_o));

    p_cfg_pe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pgm_enable |=> $stable(bootp_o));
endmodule

// File: rtl/fg_test_reg.sv
module fg_test_reg #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          special,
    input  logic          wr_tst,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] tst_o
);
    always_ff @(posedge clk) begin
        if (!rst_n || !special) tst_o <= '0;
        else if (wr_tst)        tst_o <= wdata;
    end

    p_tst_normal_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !special |=> (tst_o == '0));
endmodule

// File: rtl/fg_boot_window.sv
module fg_boot_window #(
    parameter int AW       = 16,
    parameter int BOOT_LG2 = 11
) (
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    input  logic          map_high,
    input  logic          boot_small,
    input  logic          bootp,
    output logic          req_allow,
    output logic          req_deny
);
    localparam int TOP_BITS = AW - 1 - BOOT_LG2;

    logic half_hit, big_hit, in_win;

    always_comb begin
        half_hit  = (req_addr[AW-1] == map_high);
        big_hit   = &req_addr[AW-2 -: TOP_BITS];
        in_win    = half_hit && big_hit && (!boot_small || req_addr[BOOT_LG2-1]);
        req_deny  = req_valid && bootp && in_win;
        req_allow = req_valid && !(bootp && in_win);
    end

    always_comb begin
        a_excl_r11: assert (!(req_allow && req_deny));
        a_idle_r12: assert (req_valid || (!req_allow && !req_deny));
    end
endmodule

// File: rtl/flash_guard_regs.sv
module flash_guard_regs
    import fg_pkg::*;
#(
    parameter int          AW       = 16,
    parameter int          DW       = 8,
    parameter int          RAW      = 8,
    parameter logic [7:0]  REG_BASE = 8'hF4,
    parameter int          BOOT_LG2 = 11
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           mode_special,
    input  logic [RAW-1:0] reg_addr,
    input  logic           reg_wr,
    input  logic [DW-1:0]  reg_wdata,
    output logic [DW-1:0]  reg_rdata,
    input  logic           pgm_enable,
    input  logic           map_high,
    input  logic           boot_small,
    input  logic           req_valid,
    input  logic [AW-1:0]  req_addr,
    output logic           req_allow,
    output logic           req_deny
);
    localparam logic [RAW-1:0] A_LOCK = RAW'(REG_BASE) + RAW'(REG_LOCK_OFS);
    localparam logic [RAW-1:0] A_CFG  = RAW'(REG_BASE) + RAW'(REG_CFG_OFS);
    localparam logic [RAW-1:0] A_TST  = RAW'(REG_BASE) + RAW'(REG_TST_OFS);

    logic          sel_lock, sel_cfg, sel_tst;
    logic          lock_bit, bootp_bit;
    logic [DW-1:0] tst_val;

    always_comb begin
        sel_lock = (reg_addr == A_LOCK);
        sel_cfg  = (reg_addr == A_CFG);
        sel_tst  = (reg_addr == A_TST);
    end

    fg_lock_fsm u_lock (
        .clk     (clk),
        .rst_n   (rst_n),
        .special (mode_special),
        .wr_lock (reg_wr && sel_lock),
        .wbit    (reg_wdata[0]),
        .lock_o  (lock_bit)
    );

    fg_cfg_reg u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_cfg     (reg_wr && sel_cfg),
        .lock_i     (lock_bit),
        .pgm_enable (pgm_enable),
        .wbit       (reg_wdata[0]),
        .bootp_o    (bootp_bit)
    );

    fg_test_reg #(.DW(DW)) u_tst (
        .clk     (clk),
        .rst_n   (rst_n),
        .special (mode_special),
        .wr_tst  (reg_wr && sel_tst),
        .wdata   (reg_wdata),
        .tst_o   (tst_val)
    );

    fg_boot_window #(.AW(AW), .BOOT_LG2(BOOT_LG2)) u_win (
        .req_valid  (req_valid),
        .req_addr   (req_addr),
        .map_high   (map_high),
        .boot_small (boot_small),
        .bootp      (bootp_bit),
        .req_allow  (req_allow),
        .req_deny   (req_deny)
    );

    always_comb begin
        reg_rdata = '0;
        if (sel_lock)     reg_rdata = {{(DW-1){1'b0}}, lock_bit};
        else if (sel_cfg) reg_rdata = {{(DW-1){1'b0}}, bootp_bit};
        else if (sel_tst) reg_rdata = mode_special ? tst_val : '0;
    end

    p_cfg_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && sel_cfg && !lock_bit && !pgm_enable) |=> (bootp_bit == $past(reg_wdata[0])));

    p_deny_needs_protect_r11: assert property (@(posedge clk) disable iff (!rst_n)
        req_deny |-> bootp_bit);
endmodule

// File: tb/flash_guard_regs_tb_top.sv
`timescale 1ns/1ps
module flash_guard_regs_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_special = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic        pgm_enable = 1'b0;
    logic        map_high = 1'b0;
    logic        boot_small = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] req_addr = 16'h0000;
    logic        req_allow, req_deny;

    int n_cmp = 0;
    int n_bad = 0;

    // behavioural reference state
    int m_lock, m_used, m_bootp, m_tst;

    always #2 clk = ~clk;

    flash_guard_regs dut_i (
        .clk(clk), .rst_n(rst_n), .mode_special(mode_special),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .pgm_enable(pgm_enable), .map_high(map_high),
        .boot_small(boot_small), .req_valid(req_valid), .req_addr(req_addr),
        .req_allow(req_allow), .req_deny(req_deny)
    );

    function automatic int exp_read(int a);
        case (a)
            'hF4: return m_lock;
            'hF5: return m_bootp;
            'hF6: return mode_special ? m_tst : 0;
            default: return 0;
        endcase
    endfunction

    function automatic int exp_deny();
        int lo, hi;
        hi = map_high ? 'hFFFF : 'h7FFF;
        lo = hi - (boot_small ? 'h3FF : 'h7FF);
        return (req_valid && m_bootp != 0 && int'(req_addr) >= lo && int'(req_addr) <= hi) ? 1 : 0;
    endfunction

    task automatic model_reset();
        m_lock = 0; m_used = 0; m_bootp = 1; m_tst = 0;
    endtask

    task automatic model_step();
        int d0;
        int old_lock;
        d0 = int'(reg_wdata[0]);
        old_lock = m_lock;
        if (!rst_n) begin
            model_reset();
            return;
        end
        if (reg_wr && reg_addr == 8'hF4) begin
            if (mode_special) begin
                m_lock = d0; m_used = d0;
            end else if (m_used == 0) begin
                m_lock = d0; m_used = 1;
            end
        end
        if (reg_wr && reg_addr == 8'hF5 && old_lock == 0 && !pgm_enable) m_bootp = d0;
        if (!mode_special) m_tst = 0;
        else if (reg_wr && reg_addr == 8'hF6) m_tst = int'(reg_wdata);
    endtask

    task automatic compare(string tag);
        int er, ed, ea;
        er = exp_read(int'(reg_addr));
        ed = exp_deny();
        ea = (req_valid && ed == 0) ? 1 : 0;
        n_cmp++;
        if (int'(reg_rdata) != er) begin
            n_bad++;
            $display("FAIL %s rdata@%h actual=%h expected=%h", tag, reg_addr, reg_rdata, er);
        end
        n_cmp++;
        if (int'(req_deny) != ed || int'(req_allow) != ea) begin
            n_bad++;
            $display("FAIL %s req@%h allow/deny actual=%0d/%0d expected=%0d/%0d",
                     tag, req_addr, req_allow, req_deny, ea, ed);
        end
    endtask

    // one clock: drive at negedge, compare, let the edge happen, update model
    task automatic cyc(string tag, logic [7:0] a, logic w, logic [7:0] d,
                       logic rv = 1'b0, logic [15:0] ra = 16'h0);
        reg_addr = a; reg_wr = w; reg_wdata = d; req_valid = rv; req_addr = ra;
        #1;
        if (rst_n) compare(tag);
        @(posedge clk);
        model_step();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cyc("rst", 8'h00, 1'b0, 8'h00);
        cyc("rst", 8'h00, 1'b0, 8'h00);
        rst_n = 1'b1;
    endtask

    task automatic probe(string tag, logic [15:0] ra);
        cyc(tag, 8'hF5, 1'b0, 8'h00, 1'b1, ra);
    endtask

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        model_reset();
        @(negedge clk);
        do_reset();
        // R1 reset values, R9 other addresses
        cyc("R1", 8'hF4, 0, 0);
        cyc("R1", 8'hF5, 0, 0);
        cyc("R1", 8'hF6, 0, 0);
        cyc("R9", 8'hF3, 0, 0);
        cyc("R9", 8'hF7, 0, 0);
        // R12 idle
        cyc("R12", 8'h00, 0, 0, 1'b0, 16'h7900);
        // R10 / R11 window edges, protect set
        for (int mh = 0; mh < 2; mh++) begin
            for (int sm = 0; sm < 2; sm++) begin
                map_high = mh[0]; boot_small = sm[0];
                probe("R10", 16'h77FF); probe("R10", 16'h7800);
                probe("R10", 16'h7BFF); probe("R10", 16'h7C00);
                probe("R10", 16'h7FFF); probe("R10", 16'h8000);
                probe("R10", 16'hF7FF); probe("R10", 16'hF800);
                probe("R10", 16'hFBFF); probe("R10", 16'hFC00);
                probe("R11", 16'hFFFF); probe("R11", 16'h0000);
            end
        end
        map_high = 0; boot_small = 0;
        // R5 program-enable freezes config
        pgm_enable = 1;
        cyc("R5", 8'hF5, 1, 8'h00);
        cyc("R5", 8'hF5, 0, 0);
        pgm_enable = 0;
        // R6 allowed write, R9 upper bits
        cyc("R6", 8'hF5, 1, 8'hFE);
        cyc("R6", 8'hF5, 0, 0);
        probe("R11", 16'h7800);
        probe("R11", 16'h7FFF);
        cyc("R9", 8'hF5, 1, 8'hFF);
        cyc("R9", 8'hF5, 0, 0);
        // R7 test reg in normal mode
        cyc("R7", 8'hF6, 1, 8'hA5);
        cyc("R7", 8'hF6, 0, 0);
        // R8 / R3 special mode
        mode_special = 1;
        cyc("R8", 8'hF6, 1, 8'h5A);
        cyc("R8", 8'hF6, 0, 0);
        cyc("R3", 8'hF4, 1, 8'h01);
        cyc("R3", 8'hF4, 0, 0);
        cyc("R3", 8'hF4, 1, 8'h00);
        cyc("R3", 8'hF4, 1, 8'hFF);
        cyc("R9", 8'hF4, 0, 0);
        cyc("R3", 8'hF4, 1, 8'h00);
        cyc("R3", 8'hF4, 0, 0);
        mode_special = 0;
        cyc("R8", 8'hF6, 0, 0);
        mode_special = 1;
        cyc("R8", 8'hF6, 0, 0);
        mode_special = 0;
        // R2 single normal write after special 0: write 0 consumes, write 1 ignored
        cyc("R2", 8'hF4, 1, 8'h00);
        cyc("R2", 8'hF4, 1, 8'h01);
        cyc("R2", 8'hF4, 0, 0);
        cyc("R6", 8'hF5, 1, 8'h01);
        cyc("R6", 8'hF5, 0, 0);
        probe("R11", 16'h7A00);
        // R4 lock freezes config
        do_reset();
        cyc("R2", 8'hF4, 1, 8'h01);
        cyc("R2", 8'hF4, 0, 0);
        cyc("R4", 8'hF5, 1, 8'h00);
        cyc("R4", 8'hF5, 0, 0);
        cyc("R2", 8'hF4, 1, 8'h00);
        cyc("R2", 8'hF4, 0, 0);
        probe("R4", 16'h7800);
        // reset clears lock
        do_reset();
        cyc("R1", 8'hF4, 0, 0);
        cyc("R1", 8'hF5, 0, 0);
        cyc("R6", 8'hF5, 1, 8'h00);
        cyc("R6", 8'hF5, 0, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule